// File: doc/BRIEF.md
# Two-Operand Operand Fetch Sequencer

This block is the operand-gathering control path of a small 16-bit processor. It handles one two-operand instruction at a time over a single word-wide memory port. That port allows one access per cycle and returns read data on the cycle after the request. For each instruction the block fetches the opcode word, then whatever extension words the addressing modes need, then the source operand, then a memory destination operand if the instruction has one. It presents both operands and the opcode to an external ALU, takes the ALU result back in the same cycle, and writes that result to the destination register or to the destination memory word. The program counter and an internal array of sixteen registers live inside the block. Register 0 is the program counter.

The fields of the instruction word are laid out as follows. Bits 15:12 are the opcode and go out unchanged on `alu_op`. Bits 11:8 select the source register. Bit 7 selects the destination mode. Bit 6 is a size bit that is ignored, because only word operations exist. Bits 5:4 are the source mode. Bits 3:0 select the destination register. Registers 0, 2 and 3 change what some source mode codes mean. Registers 2 and 3 also act as a constant generator that supplies six common literals without touching memory.

The controller has seven states:
- FETCH reads the word at PC, adds 2 to PC and moves to DECODE.
- DECODE latches the word. A register or constant source moves to the destination phase. An extension-word source reads at PC, adds 2 to PC and moves to SRC_EXT. An indirect source reads at the register's address and moves to SRC_MEM.
- SRC_EXT either takes the immediate value and moves to the destination phase, or forms the operand address, reads it and moves to SRC_MEM.
- SRC_MEM latches the operand and moves to the destination phase.
- The destination phase goes to EXEC for a register destination. For an indexed destination it reads the next word at PC, adds 2 to PC and moves to DST_EXT.
- DST_EXT forms the destination address, reads it and moves to DST_MEM.
- DST_MEM latches the destination operand and moves to EXEC.
- EXEC performs the write-back, raises `done` and returns to FETCH.

Top module: `operand_fetch_seq`

## Requirements
- R1: While `rst_n` is low, `done` and `mem_wr` are low. After reset the first fetch reads byte address 0.
- R2: Every word taken from the instruction stream (the opcode or an extension word) advances PC by 2. The next instruction is fetched from the address just past the last word the previous instruction used. No cycle carries both `mem_rd` and `mem_wr`.
- R3: Source mode 00 (bits 5:4) with a register other than R3 uses the register's content as the operand. With a register destination, the instruction takes 3 cycles from fetch to `done`.
- R4: Source mode 01 with a base register other than R0, R2 and R3 reads the operand at the base register plus the extension word. The instruction takes 5 cycles with a register destination.
- R5: Source mode 01 with R0 reads the operand at the byte address of the extension word plus that word's value.
- R6: Source mode 01 with R2 reads the operand at the address given by the extension word itself.
- R7: Source mode 10 with a register other than R2 and R3 reads the operand at the address held in the register. The register is left unchanged, and the instruction takes 4 cycles with a register destination.
- R8: Source mode 11 with a register other than R0, R2 and R3 reads the operand as in mode 10, then adds 2 to the register.
- R9: Source mode 11 with R0 uses the word at PC as the operand and adds 2 to PC. The instruction takes 4 cycles with a register destination.
- R10: The following literals come from the constant generator, with no extension word and no extra cycle (3 cycles with a register destination):

  | Source register | Mode 00 | Mode 01 | Mode 10 | Mode 11 |
  |---|---|---|---|---|
  | R2 | – | – | 4 | 8 |
  | R3 | 0 | 1 | 2 | 0xFFFF |
- R11: When bit 7 is 1, the destination is the memory word at base register plus extension word. Base R0 makes the address relative to that word's own address, and base R2 makes it absolute. The destination extension word follows any source extension word. The destination is read, passed on `alu_dst`, and overwritten with `alu_result`. This adds 2 cycles.
- R12: When bit 7 is 0, `alu_dst` carries the destination register and `alu_result` is written into that register, with no memory write.
- R13: `done` is high for exactly one cycle, the write-back cycle. In that cycle `alu_op` carries bits 15:12 and `alu_src` and `alu_dst` carry the operands, and no memory read is issued. The next cycle is a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Byte address of the current memory access |
| mem_rd | output | 1 | Read request; data is returned on the next cycle |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Write data (the ALU result) |
| mem_rdata | input | 16 | Read data for the previous cycle's read |
| alu_op | output | 4 | Opcode field of the current instruction |
| alu_src | output | 16 | Source operand |
| alu_dst | output | 16 | Destination operand |
| alu_result | input | 16 | Result computed combinationally by the ALU |
| done | output | 1 | Write-back cycle marker |

## Verification
The assertions depend only on the controller's own sequencing. They assume nothing about `alu_result` or `mem_rdata`, so arbitrary data cannot falsify them. The bench keeps the stimulus inside the block's intended use. It never names R0 as a register destination, since that would move the fetch stream. It never uses R0 or R1 as an indirect pointer. It keeps every base register and extension word pointing into a data area separate from the code, so the reference model never has to follow code being overwritten.

// File: rtl/opf_pkg.sv
package opf_pkg;
    localparam int WORD_W = 16;
    localparam int REG_N  = 16;
    localparam int REG_AW = $clog2(REG_N);
    localparam int OP_W   = 4;
    localparam int MODE_W = 2;

    localparam logic [REG_AW-1:0] REG_PC  = REG_AW'(0);
    localparam logic [REG_AW-1:0] REG_ABS = REG_AW'(2);
    localparam logic [REG_AW-1:0] REG_CG  = REG_AW'(3);

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_SRC_EXT, S_SRC_MEM, S_DST_EXT, S_DST_MEM, S_EXEC
    } fsm_state_t;

    typedef enum logic [2:0] {
        SC_REG, SC_CONST, SC_EXT, SC_IMM, SC_IND
    } src_class_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [REG_AW-1:0] sreg;
        logic              dst_idx;
        logic              size_b;
        logic [MODE_W-1:0] smode;
        logic [REG_AW-1:0] dreg;
    } instr_t;
endpackage

// File: rtl/opf_constgen.sv
module opf_constgen
    import opf_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [REG_AW-1:0] sreg,
    input  logic [MODE_W-1:0] smode,
    output logic              hit,
    output logic [W-1:0]      value
);
    always_comb begin
        hit   = 1'b0;
        value = '0;
        if (sreg == REG_CG) begin
            hit = 1'b1;
            unique case (smode)
                2'd0:    value = W'(0);
                2'd1:    value = W'(1);
                2'd2:    value = W'(2);
                default: value = '1;
            endcase
        end else if (sreg == REG_ABS && smode[1]) begin
            hit   = 1'b1;
            value = smode[0] ? W'(8) : W'(4);
        end
    end
endmodule

// File: rtl/opf_regfile.sv
module opf_regfile #(
    parameter int          W        = 16,
    parameter int          N        = 16,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] rd_a_sel,
    output logic [W-1:0]         rd_a,
    input  logic [$clog2(N)-1:0] rd_b_sel,
    output logic [W-1:0]         rd_b,
    output logic [W-1:0]         pc,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);
    logic [W-1:0] rf [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                rf[i] <= (i == 0) ? W'(RESET_PC) : '0;
            end
        end else if (we) begin
            rf[wa] <= wd;
        end
    end

    assign rd_a = rf[rd_a_sel];
    assign rd_b = rf[rd_b_sel];
    assign pc   = rf[0];
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
    import opf_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      mem_rdata,
    output logic [W-1:0]      mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [W-1:0]      mem_wdata,
    output logic [OP_W-1:0]   alu_op,
    output logic [W-1:0]      alu_src,
    output logic [W-1:0]      alu_dst,
    input  logic [W-1:0]      alu_result,
    output logic              done,
    input  logic [W-1:0]      pc,
    output logic [REG_AW-1:0] src_sel,
    input  logic [W-1:0]      src_val,
    output logic [REG_AW-1:0] dst_sel,
    input  logic [W-1:0]      dst_val,
    output logic [MODE_W-1:0] src_mode,
    input  logic              cg_hit,
    input  logic [W-1:0]      cg_val,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_wa,
    output logic [W-1:0]      rf_wd
);
    fsm_state_t state_q, state_d;
    logic [W-1:0] ir_q, src_q, dst_q, dea_q;
    logic [W-1:0] src_d, dst_d, dea_d;
    logic         ir_ld, src_ld, dst_ld, dea_ld, enter_dst;
    instr_t       word;
    src_class_t   cls;
    logic [W-1:0] src_base, dst_base;
    logic         unused_size;

    // In DECODE the instruction is still on the read bus; afterwards it is held.
    assign word        = instr_t'((state_q == S_DECODE) ? mem_rdata : ir_q);
    assign src_sel     = word.sreg;
    assign dst_sel     = word.dreg;
    assign src_mode    = word.smode;
    assign unused_size = word.size_b;

    always_comb begin
        if (cg_hit)                  cls = SC_CONST;
        else if (word.smode == 2'd0) cls = SC_REG;
        else if (word.smode == 2'd1) cls = SC_EXT;
        else if (word.smode == 2'd3 && word.sreg == REG_PC) cls = SC_IMM;
        else                         cls = SC_IND;
    end

    // Base of an indexed address: zero for R2, the extension word's own address for R0.
    assign src_base = (word.sreg == REG_ABS) ? '0 :
                      (word.sreg == REG_PC)  ? pc - W'(2) : src_val;
    assign dst_base = (word.dreg == REG_ABS) ? '0 :
                      (word.dreg == REG_PC)  ? pc - W'(2) : dst_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            ir_q    <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            dea_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ir_ld)  ir_q  <= mem_rdata;
            if (src_ld) src_q <= src_d;
            if (dst_ld) dst_q <= dst_d;
            if (dea_ld) dea_q <= dea_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = pc;
        mem_wdata = alu_result;
        rf_we     = 1'b0;
        rf_wa     = REG_PC;
        rf_wd     = pc + W'(2);
        ir_ld     = 1'b0;
        src_ld    = 1'b0;
        src_d     = src_val;
        dst_ld    = 1'b0;
        dst_d     = mem_rdata;
        dea_ld    = 1'b0;
        dea_d     = dst_base + mem_rdata;
        done      = 1'b0;
        enter_dst = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                mem_rd  = 1'b1;
                rf_we   = 1'b1;
                state_d = S_DECODE;
            end
            S_DECODE: begin
                ir_ld = 1'b1;
                unique case (cls)
                    SC_REG: begin
                        src_ld    = 1'b1;
                        enter_dst = 1'b1;
                    end
                    SC_CONST: begin
                        src_ld    = 1'b1;
                        src_d     = cg_val;
                        enter_dst = 1'b1;
                    end
                    SC_EXT, SC_IMM: begin
                        mem_rd  = 1'b1;
                        rf_we   = 1'b1;
                        state_d = S_SRC_EXT;
                    end
                    default: begin
                        mem_rd   = 1'b1;
                        mem_addr = src_val;
                        if (word.smode[0]) begin
                            rf_we = 1'b1;
                            rf_wa = word.sreg;
                            rf_wd = src_val + W'(2);
                        end
                        state_d = S_SRC_MEM;
                    end
                endcase
            end
            S_SRC_EXT: begin
                if (cls == SC_IMM) begin
                    src_ld    = 1'b1;
                    src_d     = mem_rdata;
                    enter_dst = 1'b1;
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = src_base + mem_rdata;
                    state_d  = S_SRC_MEM;
                end
            end
            S_SRC_MEM: begin
                src_ld    = 1'b1;
                src_d     = mem_rdata;
                enter_dst = 1'b1;
            end
            S_DST_EXT: begin
                dea_ld   = 1'b1;
                mem_rd   = 1'b1;
                mem_addr = dea_d;
                state_d  = S_DST_MEM;
            end
            S_DST_MEM: begin
                dst_ld  = 1'b1;
                state_d = S_EXEC;
            end
            S_EXEC: begin
                done = 1'b1;
                if (word.dst_idx) begin
                    mem_wr   = 1'b1;
                    mem_addr = dea_q;
                end else begin
                    rf_we = 1'b1;
                    rf_wa = word.dreg;
                    rf_wd = alu_result;
                end
                state_d = S_FETCH;
            end
            default: state_d = S_FETCH;
        endcase
        if (enter_dst) begin
            if (word.dst_idx) begin
                mem_rd  = 1'b1;
                rf_we   = 1'b1;
                state_d = S_DST_EXT;
            end else begin
                state_d = S_EXEC;
            end
        end
    end

    assign alu_op  = word.op;
    assign alu_src = src_q;
    assign alu_dst = word.dst_idx ? dst_q : dst_val;
endmodule

// File: rtl/operand_fetch_seq.sv
module operand_fetch_seq
    import opf_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [OP_W-1:0]   alu_op,
    output logic [WORD_W-1:0] alu_src,
    output logic [WORD_W-1:0] alu_dst,
    input  logic [WORD_W-1:0] alu_result,
    output logic              done
);
    logic [WORD_W-1:0] pc, src_val, dst_val, cg_val, rf_wd;
    logic [REG_AW-1:0] src_sel, dst_sel, rf_wa;
    logic [MODE_W-1:0] src_mode;
    logic              cg_hit, rf_we;

    opf_regfile #(.W(WORD_W), .N(REG_N), .RESET_PC(RESET_PC)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(src_sel), .rd_a(src_val),
        .rd_b_sel(dst_sel), .rd_b(dst_val),
        .pc(pc), .we(rf_we), .wa(rf_wa), .wd(rf_wd)
    );

    opf_constgen #(.W(WORD_W)) u_cg (
        .sreg(src_sel), .smode(src_mode), .hit(cg_hit), .value(cg_val)
    );

    opf_ctrl #(.W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .alu_op(alu_op), .alu_src(alu_src), .alu_dst(alu_dst),
        .alu_result(alu_result), .done(done),
        .pc(pc), .src_sel(src_sel), .src_val(src_val),
        .dst_sel(dst_sel), .dst_val(dst_val), .src_mode(src_mode),
        .cg_hit(cg_hit), .cg_val(cg_val),
        .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd)
    );
endmodule

// File: rtl/operand_fetch_seq_chk.sv
module opf_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd,
    input logic mem_wr,
    input logic done
);
    // R2
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11
    write_in_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> done);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    fetch_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (mem_rd && !mem_wr));

    // R13
    no_read_in_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd);
endmodule

bind operand_fetch_seq opf_seq_chk u_opf_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done)
);

// File: tb/operand_fetch_seq_test.sv
`timescale 1ns/1ps
module operand_fetch_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, alu_src, alu_dst, alu_result;
    logic        mem_rd, mem_wr, done;
    logic [3:0]  alu_op;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] mem [2048];
    logic [15:0] mm  [2048];
    logic [15:0] mr  [16];
    logic [15:0] cur = 16'h0000;
    int          n = 0;

    logic [15:0] e_pc [256];
    logic [15:0] e_src [256];
    logic [15:0] e_dst [256];
    logic [15:0] e_res [256];
    logic [15:0] e_ea [256];
    logic [3:0]  e_op [256];
    logic        e_ad [256];
    int          e_cyc [256];
    string       e_sq [256];

    always #2 clk = ~clk;

    operand_fetch_seq uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .alu_op(alu_op), .alu_src(alu_src), .alu_dst(alu_dst),
        .alu_result(alu_result), .done(done)
    );

    function automatic logic [15:0] alu_f(input logic [3:0] op, input logic [15:0] s, input logic [15:0] d);
        case (op)
            4'd4:    return s;
            4'd5:    return s + d;
            4'd6:    return d - s;
            default: return s ^ d;
        endcase
    endfunction

    always_comb alu_result = alu_f(alu_op, alu_src, alu_dst);

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:1]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:1]];
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        mem[cur[11:1]] = w;
        mm[cur[11:1]]  = w;
        cur = cur + 16'd2;
    endtask

    task automatic gen(input logic [3:0] op, input logic [3:0] sr, input logic [1:0] as,
                       input logic ad, input logic [3:0] dr, input logic [15:0] sx, input logic [15:0] dx);
        logic [15:0] sv, dv, ea, rv;
        int    cy;
        string sq;
        e_pc[n] = cur;
        put({op, sr, ad, 1'b0, as, dr});
        cy = 3;
        ea = 16'h0;
        if (sr == 4'd3) begin
            sq = "R10";
            case (as)
                2'd0:    sv = 16'h0000;
                2'd1:    sv = 16'h0001;
                2'd2:    sv = 16'h0002;
                default: sv = 16'hFFFF;
            endcase
        end else if (sr == 4'd2 && as[1]) begin
            sq = "R10";
            sv = as[0] ? 16'd8 : 16'd4;
        end else if (as == 2'd0) begin
            sq = "R3";
            sv = mr[sr];
        end else if (as == 2'd1) begin
            cy += 2;
            if (sr == 4'd0) begin sq = "R5"; ea = sx; put(sx - cur); end
            else if (sr == 4'd2) begin sq = "R6"; ea = sx; put(sx); end
            else begin sq = "R4"; ea = mr[sr] + sx; put(sx); end
            sv = mm[ea[11:1]];
        end else if (as == 2'd3 && sr == 4'd0) begin
            sq = "R9";
            cy += 1;
            sv = sx;
            put(sx);
        end else begin
            cy += 1;
            sq = as[0] ? "R8" : "R7";
            ea = mr[sr];
            sv = mm[ea[11:1]];
            if (as[0]) mr[sr] = mr[sr] + 16'd2;
        end
        if (ad) begin
            cy += 2;
            if (dr == 4'd0) begin ea = dx; put(dx - cur); end
            else if (dr == 4'd2) begin ea = dx; put(dx); end
            else begin ea = mr[dr] + dx; put(dx); end
            dv = mm[ea[11:1]];
        end else begin
            dv = mr[dr];
        end
        rv = alu_f(op, sv, dv);
        if (ad) mm[ea[11:1]] = rv;
        else    mr[dr] = rv;
        e_src[n] = sv; e_dst[n] = dv; e_res[n] = rv; e_ea[n] = ea;
        e_op[n] = op; e_ad[n] = ad; e_cyc[n] = cy; e_sq[n] = sq;
        n++;
    endtask

    initial begin
        int k;
        logic [3:0]  dr;
        logic [15:0] sx, dx;
        for (int i = 0; i < 2048; i++) begin
            mem[i] = (i >= 1024) ? (16'(i) * 16'h9E37) ^ 16'h5A5A : 16'h0000;
            mm[i]  = mem[i];
        end
        for (int r = 0; r < 16; r++) mr[r] = 16'h0000;
        // Load registers with immediates (R9)
        for (int r = 4; r < 16; r++) begin
            sx = (r < 8) ? 16'h0900 + 16'(r - 4) * 16'h0100 : 16'(r) * 16'h1357;
            gen(4'd4, 4'd0, 2'd3, 1'b0, 4'(r), sx, 16'h0);
        end
        // Sweep every source mode against both destination modes
        k = 0;
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 8; s++) begin
                for (int d = 0; d < 2; d++) begin
                    if (s == 1) continue;
                    if (s == 0 && a[0] == 1'b0) continue;
                    if (s == 0 && a == 1)      sx = 16'h0E80 + 16'(2 * (k % 32));
                    else if (s == 0 && a == 3) sx = 16'(k) * 16'h0123 + 16'd7;
                    else if (s == 2 && a == 1) sx = 16'h0D00 + 16'(2 * (k % 32));
                    else if (a == 1)           sx = 16'h0010 + 16'(2 * (k % 16));
                    else                       sx = 16'h0000;
                    if (d == 0) begin
                        dr = 4'(8 + k % 8);
                        dx = 16'h0;
                    end else if (k % 3 == 0) begin
                        dr = 4'd2;
                        dx = 16'h0E00 + 16'(2 * (k % 64));
                    end else if (k % 3 == 1) begin
                        dr = 4'd0;
                        dx = 16'h0F00 + 16'(2 * (k % 32));
                    end else begin
                        dr = 4'(4 + k % 4);
                        dx = 16'h0020 + 16'(2 * (k % 16));
                    end
                    gen(4'(4 + k % 4), 4'(s), 2'(a), d[0], dr, sx, dx);
                    k++;
                end
            end
        end
        // Store every register through an absolute destination to expose final values
        for (int r = 4; r < 16; r++) begin
            gen(4'd4, 4'(r), 2'd0, 1'b1, 4'd2, 16'h0, 16'h0F80 + 16'(2 * r));
        end
        e_pc[n] = cur;

        repeat (3) @(negedge clk);
        chk("R1", "done in reset", 32'(done), 32'd0);
        chk("R1", "mem_wr in reset", 32'(mem_wr), 32'd0);
        rst_n = 1'b1;
        #1;
        for (int i = 0; i < n; i++) begin
            int cyc;
            chk((i == 0) ? "R1" : "R2", "fetch read", 32'(mem_rd && !mem_wr), 32'd1);
            chk((i == 0) ? "R1" : "R2", "fetch address", 32'(mem_addr), 32'(e_pc[i]));
            cyc = 1;
            while (!done) begin
                @(negedge clk);
                cyc++;
            end
            chk(e_ad[i] ? "R11" : e_sq[i], "cycles", 32'(cyc), 32'(e_cyc[i]));
            chk(e_sq[i], "alu_src", 32'(alu_src), 32'(e_src[i]));
            chk(e_ad[i] ? "R11" : "R12", "alu_dst", 32'(alu_dst), 32'(e_dst[i]));
            chk("R13", "alu_op", 32'(alu_op), 32'(e_op[i]));
            chk("R13", "no read in write-back", 32'(mem_rd), 32'd0);
            if (e_ad[i]) begin
                chk("R11", "mem_wr", 32'(mem_wr), 32'd1);
                chk("R11", "write address", 32'(mem_addr), 32'(e_ea[i]));
                chk("R11", "write data", 32'(mem_wdata), 32'(e_res[i]));
            end else begin
                chk("R12", "no memory write", 32'(mem_wr), 32'd0);
            end
            @(negedge clk);
            chk("R13", "done single cycle", 32'(done), 32'd0);
        end
        chk("R2", "final fetch address", 32'(mem_addr), 32'(e_pc[n]));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R13 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule